// File: doc/BRIEF.md
# Synthesizer Configuration Word Register

This block holds the configuration word of a clock synthesizer: a 3-bit test-select field, a 2-bit output-divider code and a 9-bit feedback-divider value. The word reaches the block in one of two ways. It can be shifted in one bit at a time on a serial data line, with each rising edge of a serial clock, and then committed by a load strobe. Or the two divider fields can be captured straight from parallel pins by a parallel-load strobe.

All strobes are sampled in the block's own clock domain, which must run faster than any of them. Each control line is edge-detected against its previous sample. The caller is expected to present serial clock, serial data, serial load and parallel load synchronously to `clk_i`. Serial data must be stable at the sample where the serial clock is first seen high, and the serial clock edges of a word must come before that word's load strobe.

While the parallel-load line is high, the test-select latch is held cleared. During that time the first-shifted stage of the shift register drives the readback output, so a test multiplexer can observe what was shifted in.

Top module: `synth_cfg_reg`

## Requirements
- R1: After rst_ni is released, test_sel_o, n_div_o and m_div_o are all zero and the shift register holds zero.
- R2: Each rising edge of sclk_i shifts sdata_i into the 14-bit shift register, so the first bit of a 14-bit burst ends up in the top stage (bit 13) and the last bit ends up in bit 0.
- R3: The shift register fields are laid out as test select in bits 13..11 (first bit = test bit 2), output divider in bits 10..9, and feedback divider in bits 8..0 (last bit = M bit 0).
- R4: A rising edge of sload_i while pload_i is low copies all 14 shift-register bits into the three outputs, which are visible on the next clock. The values copied are the ones held before any shift in that same cycle.
- R5: With no rising edge on sload_i or pload_i and pload_i low, the outputs hold their values, including while serial bits are being shifted.
- R6: Keeping sload_i high causes no further loads; only its rising edge loads.
- R7: A rising edge of pload_i captures m_par_i into m_div_o and n_par_i into n_div_o.
- R8: When rising edges of pload_i and sload_i coincide, m_div_o and n_div_o take the parallel pins, not the shift register.
- R9: While pload_i is high, test_sel_o is forced to 000, and a serial load cannot change it. The divider fields still load from the shift register on a rising edge of sload_i without a pload_i edge.
- R10: rdbk_o equals shift-register bit 13 while pload_i is high, and is 0 while pload_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; samples all strobes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; each rising edge shifts one bit |
| sdata_i | input | 1 | Serial data bit |
| sload_i | input | 1 | Serial load strobe; rising edge commits the word |
| pload_i | input | 1 | Parallel load; rising edge captures dividers, high level clears test select |
| m_par_i | input | 9 | Parallel feedback-divider value |
| n_par_i | input | 2 | Parallel output-divider code |
| test_sel_o | output | 3 | Latched test-select field |
| n_div_o | output | 2 | Latched output-divider code |
| m_div_o | output | 9 | Latched feedback-divider value |
| rdbk_o | output | 1 | Serial readback of the first-shifted stage |

## Verification
The assertions check several rules on every cycle: each serial edge moves the word by one bit with the new bit at the bottom, a serial load reproduces the shift word exactly, a parallel edge captures the pins, the outputs stay frozen when no load edge occurs, the test field stays clear while parallel load is high, and readback is low unless parallel load is high. Only the bench scenarios can show the end-to-end bit order: a word presented first bit to last lands in the intended fields. The bench scenarios also cover the reset values, that holding the load strobe high does not reload, and that the readback reports the first-shifted bit of real traffic. Random words with randomly placed parallel loads exercise the priority between the two load paths.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned T_W_DEF = 3;
  localparam int unsigned N_W_DEF = 2;
  localparam int unsigned M_W_DEF = 9;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SER  = 2'd1,
    SRC_PAR  = 2'd2
  } div_src_e;
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  // new bit enters at bit 0; first bit migrates to the top stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[W-2:0], din_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/cfg_hold_regs.sv
module cfg_hold_regs
  import cfg_pkg::*;
#(
  parameter int unsigned T_W = T_W_DEF,
  parameter int unsigned N_W = N_W_DEF,
  parameter int unsigned M_W = M_W_DEF,
  localparam int unsigned WORD_W = T_W + N_W + M_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sh_word_i,
  input  logic              ser_load_i,
  input  logic              par_load_i,
  input  logic              par_level_i,
  input  logic [M_W-1:0]    m_par_i,
  input  logic [N_W-1:0]    n_par_i,
  output logic [T_W-1:0]    tsel_o,
  output logic [N_W-1:0]    ndiv_o,
  output logic [M_W-1:0]    mdiv_o
);
  localparam int unsigned T_LO = N_W + M_W;

  logic [T_W-1:0] tsel_q;
  logic [N_W-1:0] ndiv_q, ndiv_d;
  logic [M_W-1:0] mdiv_q, mdiv_d;
  div_src_e       src;

  // parallel edge wins over serial load for the divider fields
  always_comb begin
    if (par_load_i)      src = SRC_PAR;
    else if (ser_load_i) src = SRC_SER;
    else                 src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_PAR: begin
        ndiv_d = n_par_i;
        mdiv_d = m_par_i;
      end
      SRC_SER: begin
        ndiv_d = sh_word_i[M_W +: N_W];
        mdiv_d = sh_word_i[0 +: M_W];
      end
      default: begin
        ndiv_d = ndiv_q;
        mdiv_d = mdiv_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ndiv_q <= '0;
      mdiv_q <= '0;
    end else begin
      ndiv_q <= ndiv_d;
      mdiv_q <= mdiv_d;
    end
  end

  // parallel-load level holds the test field cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tsel_q <= '0;
    else if (par_level_i) tsel_q <= '0;
    else if (ser_load_i)  tsel_q <= sh_word_i[T_LO +: T_W];
  end

  assign tsel_o = tsel_q;
  assign ndiv_o = ndiv_q;
  assign mdiv_o = mdiv_q;
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import cfg_pkg::*;
#(
  parameter int unsigned T_W = T_W_DEF,
  parameter int unsigned N_W = N_W_DEF,
  parameter int unsigned M_W = M_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  input  logic           pload_i,
  input  logic [M_W-1:0] m_par_i,
  input  logic [N_W-1:0] n_par_i,
  output logic [T_W-1:0] test_sel_o,
  output logic [N_W-1:0] n_div_o,
  output logic [M_W-1:0] m_div_o,
  output logic           rdbk_o
);
  localparam int unsigned WORD_W = T_W + N_W + M_W;
  localparam int unsigned NSTRB  = 3;

  logic [NSTRB-1:0]  strb, strb_rise;
  logic [WORD_W-1:0] sh_word;

  assign strb = {pload_i, sload_i, sclk_i};

  cfg_edge_det #(.W(NSTRB)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (strb),
    .rise_o(strb_rise)
  );

  cfg_shift_chain #(.W(WORD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (strb_rise[0]),
    .din_i (sdata_i),
    .word_o(sh_word)
  );

  cfg_hold_regs #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sh_word_i  (sh_word),
    .ser_load_i (strb_rise[1]),
    .par_load_i (strb_rise[2]),
    .par_level_i(pload_i),
    .m_par_i    (m_par_i),
    .n_par_i    (n_par_i),
    .tsel_o     (test_sel_o),
    .ndiv_o     (n_div_o),
    .mdiv_o     (m_div_o)
  );

  // first-shifted stage is visible only while the test latch is held cleared
  assign rdbk_o = pload_i & sh_word[WORD_W-1];
endmodule

// File: rtl/synth_cfg_reg_chk.sv
module synth_cfg_reg_chk #(
  parameter int unsigned T_W = 3,
  parameter int unsigned N_W = 2,
  parameter int unsigned M_W = 9,
  localparam int unsigned WORD_W = T_W + N_W + M_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              sdata_i,
  input logic              sload_i,
  input logic              pload_i,
  input logic [M_W-1:0]    m_par_i,
  input logic [N_W-1:0]    n_par_i,
  input logic [T_W-1:0]    test_sel_o,
  input logic [N_W-1:0]    n_div_o,
  input logic [M_W-1:0]    m_div_o,
  input logic              rdbk_o,
  input logic [WORD_W-1:0] sh_word
);
  // R2
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |=> sh_word == {$past(sh_word[WORD_W-2:0]), $past(sdata_i)});

  // R4
  ser_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sload_i) && !pload_i) |=> {test_sel_o, n_div_o, m_div_o} == $past(sh_word));

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(sload_i) && !pload_i) |=>
      ($stable(test_sel_o) && $stable(n_div_o) && $stable(m_div_o)));

  // R7
  par_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pload_i) |=> (m_div_o == $past(m_par_i) && n_div_o == $past(n_par_i)));

  // R9
  tsel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pload_i |=> test_sel_o == '0);

  // R10
  rdbk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_i |-> !rdbk_o);
endmodule

bind synth_cfg_reg synth_cfg_reg_chk #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_i    (sclk_i),
  .sdata_i   (sdata_i),
  .sload_i   (sload_i),
  .pload_i   (pload_i),
  .m_par_i   (m_par_i),
  .n_par_i   (n_par_i),
  .test_sel_o(test_sel_o),
  .n_div_o   (n_div_o),
  .m_div_o   (m_div_o),
  .rdbk_o    (rdbk_o),
  .sh_word   (sh_word)
);

// File: tb/synth_cfg_reg_test.sv
module synth_cfg_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0, pload = 1'b0;
  logic [8:0] m_par = '0;
  logic [1:0] n_par = '0;
  logic [2:0] tsel;
  logic [1:0] ndiv;
  logic [8:0] mdiv;
  logic       rdbk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [13:0] e_sh = '0;
  logic [2:0]  e_t  = '0;
  logic [1:0]  e_n  = '0;
  logic [8:0]  e_m  = '0;

  always #4 clk = ~clk;

  synth_cfg_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .pload_i(pload), .m_par_i(m_par), .n_par_i(n_par),
    .test_sel_o(tsel), .n_div_o(ndiv), .m_div_o(mdiv), .rdbk_o(rdbk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, {29'd0, tsel}, {29'd0, e_t});
    chk(req, {30'd0, ndiv}, {30'd0, e_n});
    chk(req, {23'd0, mdiv}, {23'd0, e_m});
  endtask

  // bench model: first bit lands in bit 13
  function automatic logic [13:0] shift_model(input logic [13:0] s, input logic b);
    return {s[12:0], b};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    e_sh = shift_model(e_sh, b);
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic ser_load();
    @(negedge clk); sload = 1'b1;
    @(negedge clk); sload = 1'b0;
    if (!pload) e_t = e_sh[13:11];
    e_n = e_sh[10:9];
    e_m = e_sh[8:0];
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_outs("R1");
    pload = 1'b1; #1;
    chk("R1 R10", {31'd0, rdbk}, 32'd0);
    @(negedge clk); pload = 1'b0;
    e_n = '0; e_m = '0;

    // R2 R3 R4 R5: field layout with distinct bit patterns
    send_word({3'b101, 2'b10, 9'h1C3});
    chk_outs("R5 during shift");
    ser_load();
    chk("R3 test", {29'd0, tsel}, 32'h5);
    chk("R3 ndiv", {30'd0, ndiv}, 32'h2);
    chk("R3 mdiv", {23'd0, mdiv}, 32'h1C3);

    // R2 first bit only -> bit 13
    send_word(14'h2000);
    chk_outs("R5");
    ser_load();
    chk("R2 first bit", {29'd0, tsel}, 32'h4);
    chk("R2 last bit", {23'd0, mdiv}, 32'h0);

    // R6 hold sload high while shifting: no reload
    @(negedge clk); sload = 1'b1;
    @(negedge clk);
    e_t = e_sh[13:11]; e_n = e_sh[10:9]; e_m = e_sh[8:0];
    send_word(14'h3FFF);
    chk_outs("R6");
    @(negedge clk); sload = 1'b0;
    chk_outs("R6");

    // R10 readback of first-shifted stage
    m_par = 9'h0A5; n_par = 2'b01;
    @(negedge clk); pload = 1'b1; #1;
    chk("R10", {31'd0, rdbk}, {31'd0, e_sh[13]});
    @(negedge clk);
    e_t = '0; e_n = 2'b01; e_m = 9'h0A5;
    chk_outs("R7 R9");
    // R9 serial load while pload high: test stays 000, dividers from shift
    send_word({3'b111, 2'b11, 9'h055});
    ser_load();
    chk_outs("R9");
    chk("R10", {31'd0, rdbk}, 32'd1);
    @(negedge clk); pload = 1'b0; #1;
    chk("R10 low", {31'd0, rdbk}, 32'd0);

    // R8 simultaneous edges
    send_word({3'b011, 2'b00, 9'h1FF});
    m_par = 9'h012; n_par = 2'b10;
    @(negedge clk); pload = 1'b1; sload = 1'b1;
    @(negedge clk); sload = 1'b0;
    e_t = '0; e_n = 2'b10; e_m = 9'h012;
    chk_outs("R8");
    @(negedge clk); pload = 1'b0;

    // R4 shift and load in same cycle: load takes pre-shift word
    send_word({3'b110, 2'b01, 9'h0F0});
    @(negedge clk); sload = 1'b1; sclk = 1'b1; sdata = 1'b1;
    @(negedge clk); sload = 1'b0; sclk = 1'b0;
    e_t = 3'b110; e_n = 2'b01; e_m = 9'h0F0;
    e_sh = shift_model(e_sh, 1'b1);
    chk_outs("R4 same cycle");

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [13:0] w;
      w = 14'($urandom);
      send_word(w);
      chk_outs("R5 rand");
      if ($urandom_range(3) == 0) begin
        m_par = 9'($urandom); n_par = 2'($urandom);
        @(negedge clk); pload = 1'b1; #1;
        chk("R10 rand", {31'd0, rdbk}, {31'd0, w[13]});
        @(negedge clk);
        e_t = '0; e_n = n_par; e_m = m_par;
        chk_outs("R7 rand");
        @(negedge clk); pload = 1'b0;
      end else begin
        ser_load();
        chk_outs("R4 rand");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule